// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns a 10-bit virtual address into an 8-bit physical address for a small system that uses one flat page table. Pages are 16 bytes. The low four bits of the address are the offset inside the page, and they pass through untouched. The six bits above them select one of 64 table entries. Each entry gives a physical page number. The table lives inside the unit, and software fills it through a dedicated write port that names an entry, a valid flag and a page number.

Only the lower 128 bytes of the 256-byte physical space hold real memory. A lookup therefore faults in two cases:

- the entry is not marked valid;
- the entry is valid but points at physical page 8 or higher, which lies past the installed memory.

Several virtual pages may point at the same physical page. Such aliases are legal and translate to identical physical addresses.

Each request returns its result one cycle later through a response strobe, the physical address and a fault flag. Reset marks every entry as unmapped.

Top module: `paged_xlate`

## Requirements
- R1: While `rst` is high and on the cycle after it, `rsp_valid_o` and `fault_o` are 0. A reset leaves all 64 entries unmapped, so any request made after reset and before a new write faults.
- R2: `rsp_valid_o` is 1 on exactly those cycles that follow a cycle with `req_i` high.
- R3: On a response, `pa_o[3:0]` equals bits [3:0] of the requesting `va_i`.
- R4: When the entry selected by `va_i[9:4]` is valid and its page number is 0 to 7, the response has `fault_o` = 0 and `pa_o[7:4]` equal to that page number.
- R5: When the selected entry is not valid, the response has `fault_o` = 1.
- R6: When the selected entry is valid but its page number is 8 to 15, the response has `fault_o` = 1. Every response without a fault has `pa_o` below 128.
- R7: A write with `wr_en_i` high changes the lookup result only for requests made on a later cycle. A request made in the same cycle as the write sees the entry's previous contents.
- R8: Two virtual pages mapped to the same physical page give the same `pa_o` for the same offset.
- R9: `fault_o` is 0 on every cycle where `rsp_valid_o` is 0.
- R10: Writing an entry with `wr_valid_i` = 0 removes its mapping, so later requests to that page fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Translation request |
| va_i | input | 10 | Virtual address for the request |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 6 | Entry (virtual page) to write |
| wr_valid_i | input | 1 | Valid flag to store |
| wr_ppn_i | input | 4 | Physical page number to store |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| pa_o | output | 8 | Translated physical address (meaningless when faulted) |
| fault_o | output | 1 | Unmapped page or page beyond installed memory |

## Verification
A table of addresses is run against the following entries, each of which must give a fault or a particular physical address:

| Entry | Case |
|---|---|
| Valid, in range | Correct translation |
| Valid, page 7 | Highest installed page |
| Valid, page 8 | First page that must fault |
| Valid, page 9 | Page beyond installed memory |
| Written with the valid flag clear | Must fault |
| Never written | Must fault |

Two virtual pages that share one physical page check that aliases translate the same way. Directed cases then cover:

- a write and a request to the same entry in one cycle, which shows whether the old or the new entry was used;
- removing a mapping;
- faults after a reset that follows earlier mappings, which shows that reset really clears the table;
- idle cycles, which show that no stray strobe or fault appears.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int DEF_VA_W            = 10;
  localparam int DEF_PA_W            = 8;
  localparam int DEF_OFF_W           = 4;
  localparam int DEF_INSTALLED_BYTES = 128;

  // True when a physical page lies fully inside installed memory.
  function automatic logic page_installed(input int ppn, input int pages);
    return (ppn < pages);
  endfunction
endpackage

// File: rtl/pxl_usable_bits.sv
// One resettable flag per entry: set only for a valid, in-range mapping.
module pxl_usable_bits #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6,
  parameter int PPN_W   = 4,
  parameter int PAGES   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             usable_q
);
  logic [ENTRIES-1:0] usable;
  logic               wr_usable;

  always_comb begin
    wr_usable = wr_valid && pxl_pkg::page_installed(int'(wr_ppn), PAGES);
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          usable[g] <= 1'b0;
        end else if (wr_en && (wr_idx == IDX_W'(g))) begin
          usable[g] <= wr_usable;
        end
      end
    end
  endgenerate

  // Idle cycles read as usable so that the fault output stays low.
  always_ff @(posedge clk) begin
    if (rst) begin
      usable_q <= 1'b1;
    end else if (rd_en) begin
      usable_q <= usable[rd_idx];
    end else begin
      usable_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pxl_ppn_ram.sv
// Simple dual-port memory, read-first, registered read: maps onto block RAM.
module pxl_ppn_ram #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/paged_xlate.sv
module paged_xlate #(
  parameter int VA_W            = pxl_pkg::DEF_VA_W,
  parameter int PA_W            = pxl_pkg::DEF_PA_W,
  parameter int OFF_W           = pxl_pkg::DEF_OFF_W,
  parameter int INSTALLED_BYTES = pxl_pkg::DEF_INSTALLED_BYTES,
  localparam int VPN_W          = VA_W - OFF_W,
  localparam int PPN_W          = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             fault_o
);
  localparam int ENTRIES = 1 << VPN_W;
  localparam int PAGES   = INSTALLED_BYTES >> OFF_W;

  logic             wr_ok;
  logic             rd_ok;
  logic [VPN_W-1:0] vpn;
  logic [PPN_W-1:0] ppn_q;
  logic [OFF_W-1:0] off_q;
  logic             usable_q;
  logic             rsp_q;

  always_comb begin
    wr_ok = wr_en_i && !rst;
    rd_ok = req_i && !rst;
    vpn   = va_i[VA_W-1:OFF_W];
  end

  pxl_usable_bits #(
    .ENTRIES(ENTRIES), .IDX_W(VPN_W), .PPN_W(PPN_W), .PAGES(PAGES)
  ) u_usable (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_ok),
    .wr_idx   (wr_idx_i),
    .wr_valid (wr_valid_i),
    .wr_ppn   (wr_ppn_i),
    .rd_en    (rd_ok),
    .rd_idx   (vpn),
    .usable_q (usable_q)
  );

  pxl_ppn_ram #(
    .DEPTH(ENTRIES), .ADDR_W(VPN_W), .DATA_W(PPN_W)
  ) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wr_idx_i),
    .wdata (wr_ppn_i),
    .re    (rd_ok),
    .raddr (vpn),
    .rdata (ppn_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q <= 1'b0;
      off_q <= '0;
    end else begin
      rsp_q <= req_i;
      if (req_i) begin
        off_q <= va_i[OFF_W-1:0];
      end
    end
  end

  always_comb begin
    rsp_valid_o = rsp_q;
    pa_o        = {ppn_q, off_q};
    fault_o     = !usable_q;
  end
endmodule

// File: rtl/pxl_checker.sv
module pxl_checker #(
  parameter int VA_W            = 10,
  parameter int PA_W            = 8,
  parameter int OFF_W           = 4,
  parameter int INSTALLED_BYTES = 128,
  localparam int VPN_W          = VA_W - OFF_W,
  localparam int PPN_W          = PA_W - OFF_W
) (
  input logic             clk,
  input logic             rst,
  input logic             req_i,
  input logic [VA_W-1:0]  va_i,
  input logic             wr_en_i,
  input logic [VPN_W-1:0] wr_idx_i,
  input logic             wr_valid_i,
  input logic [PPN_W-1:0] wr_ppn_i,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  pa_o,
  input logic             fault_o
);
  localparam int PAGES = INSTALLED_BYTES >> OFF_W;

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rsp_valid_o && !fault_o));

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    req_i |=> rsp_valid_o);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !rsp_valid_o);

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (pa_o[OFF_W-1:0] == $past(va_i[OFF_W-1:0])));

  a_r6_pa_in_range: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && !fault_o) |-> (int'(pa_o) < INSTALLED_BYTES));

  a_r9_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid_o |-> !fault_o);

  a_r7_write_visible: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_valid_i && (int'(wr_ppn_i) < PAGES))
      ##1 (req_i && (va_i[VA_W-1:OFF_W] == $past(wr_idx_i)))
      |=> (!fault_o && (pa_o[PA_W-1:OFF_W] == $past(wr_ppn_i, 2))));
endmodule

bind paged_xlate pxl_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .INSTALLED_BYTES(INSTALLED_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .va_i(va_i),
  .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_valid_i(wr_valid_i),
  .wr_ppn_i(wr_ppn_i), .rsp_valid_o(rsp_valid_o), .pa_o(pa_o),
  .fault_o(fault_o)
);

// File: tb/tb_paged_xlate.sv
module tb_paged_xlate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_i = 1'b0;
  logic [9:0] va_i = '0;
  logic       wr_en_i = 1'b0;
  logic [5:0] wr_idx_i = '0;
  logic       wr_valid_i = 1'b0;
  logic [3:0] wr_ppn_i = '0;
  logic       rsp_valid_o;
  logic [7:0] pa_o;
  logic       fault_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  paged_xlate dut (
    .clk(clk), .rst(rst), .req_i(req_i), .va_i(va_i),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_valid_i(wr_valid_i),
    .wr_ppn_i(wr_ppn_i), .rsp_valid_o(rsp_valid_o), .pa_o(pa_o),
    .fault_o(fault_o)
  );

  // {va[9:0], expected fault, expected pa[7:0]}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {10'h005, 1'b0, 8'h35},  // vpn0 -> page 3
    {10'h01A, 1'b0, 8'h3A},  // vpn1 -> page 3 (alias)
    {10'h00A, 1'b0, 8'h3A},  // vpn0, same byte as above
    {10'h02F, 1'b1, 8'h00},  // vpn2 -> page 9, beyond memory
    {10'h05F, 1'b0, 8'h7F},  // vpn5 -> page 7, last installed byte
    {10'h060, 1'b1, 8'h00},  // vpn6 -> page 8, first missing page
    {10'h3F1, 1'b0, 8'h01},  // vpn63 -> page 0
    {10'h041, 1'b1, 8'h00},  // vpn4 written invalid
    {10'h030, 1'b1, 8'h00},  // vpn3 never written
    {10'h3FF, 1'b0, 8'h0F}   // vpn63, top offset
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit v, input int ppn);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 6'(idx); wr_valid_i = v; wr_ppn_i = 4'(ppn);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // Request, then sample after the capturing edge.
  task automatic lookup(input logic [9:0] va);
    @(negedge clk);
    req_i = 1'b1; va_i = va;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rsp_valid after reset", rsp_valid_o, 0);
    check("R1 fault after reset", fault_o, 0);
    lookup(10'h005);
    check("R1 empty table faults", fault_o, 1);
    check("R2 strobe", rsp_valid_o, 1);
    @(negedge clk);
    check("R2 strobe drops", rsp_valid_o, 0);
    check("R9 fault quiet when idle", fault_o, 0);

    wr(0, 1, 3); wr(1, 1, 3); wr(2, 1, 9); wr(5, 1, 7);
    wr(6, 1, 8); wr(63, 1, 0); wr(4, 0, 2);

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][18:9]);
      check("R2 strobe", rsp_valid_o, 1);
      if (VEC[i][8]) begin
        check("R5/R6 fault", fault_o, 1);
      end else begin
        check("R4 no fault", fault_o, 0);
        check("R3/R4 pa", pa_o, VEC[i][7:0]);
      end
    end

    // R8: both aliases reach the same byte
    lookup(10'h005);
    check("R8 alias a", pa_o, 8'h35);
    lookup(10'h015);
    check("R8 alias b", pa_o, 8'h35);

    // R7: write and request to vpn3 in the same cycle
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 6'd3; wr_valid_i = 1'b1; wr_ppn_i = 4'd1;
    req_i = 1'b1; va_i = 10'h036;
    @(negedge clk);
    wr_en_i = 1'b0; req_i = 1'b0;
    check("R7 same-cycle sees old", fault_o, 1);
    lookup(10'h036);
    check("R7 next request sees new", fault_o, 0);
    check("R7 new pa", pa_o, 8'h16);

    // R10: unmap vpn0
    wr(0, 0, 3);
    lookup(10'h005);
    check("R10 removed mapping faults", fault_o, 1);
    lookup(10'h015);
    check("R10 alias kept", fault_o, 0);

    // R1: reset clears earlier mappings
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 quiet in reset", rsp_valid_o, 0);
    rst = 1'b0;
    lookup(10'h05F);
    check("R1 mapping cleared", fault_o, 1);
    @(negedge clk);
    check("R9 idle fault", fault_o, 0);
    finish_run();
  end
endmodule